// File: doc/BRIEF.md
# Capability Jump Unit with Interrupt-Posture Sentries

This block completes indirect jumps and jump-and-link operations on a small capability-based core. It is given the target capability (validity tag, permission bits, a 3-bit object type and the address) and decides whether the jump is allowed. A legal jump loads the program counter with the target address. It also updates a global interrupt-enable flag according to the interrupt posture carried by a sentry object type. A sentry is a sealed entry capability, and it is unsealed automatically when jumped through. An illegal jump raises a one-cycle fault with a cause code and leaves all architectural state alone.

For jump-and-link, the block also produces the return capability and a one-cycle write strobe for the link register. This return capability is sealed as a sentry, and its posture records the interrupt-enable state that was in force when the jump issued. Returning through it restores that state. The program counter and the interrupt flag change at the same clock edge, so the new interrupt state governs the first instruction fetched at the target. Instruction decode and the full capability bit layout are handled elsewhere. This block only sees the decoded fields.

Top module: `sentry_jump_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit sets `pc` to `RESET_PC` (default 0), clears `irq_en`, and drives `fault`, `link_we` and `fault_cause` to 0.
- R2: A jump with `tgt_tag` = 0 pulses `fault` for one cycle with `fault_cause` = 1. It leaves `pc` and `irq_en` unchanged and does not assert `link_we`.
- R3: A tagged target whose `tgt_otype` is 4 to 7 (a non-entry sealed type) pulses `fault` with `fault_cause` = 2. It leaves `pc`, `irq_en` and the link register untouched.
- R4: A tagged target with `tgt_otype` 0 to 3 whose execute permission, bit 1 of `tgt_perm`, is clear faults with `fault_cause` = 3. The cause priority is tag (1), then seal (2), then permission (3).
- R5: A legal jump through an unsealed target (`tgt_otype` = 0) loads `pc` with `tgt_addr` in the cycle after the request and leaves `irq_en` unchanged.
- R6: A legal jump through an inheriting sentry (`tgt_otype` = 1) is unsealed, loads `pc` with `tgt_addr`, and leaves `irq_en` unchanged.
- R7: A legal jump through an interrupt-off sentry (`tgt_otype` = 2) clears `irq_en` at the same edge that loads `pc`.
- R8: A legal jump through an interrupt-on sentry (`tgt_otype` = 3) sets `irq_en` at the same edge that loads `pc`.
- R9: A legal jump-and-link pulses `link_we` for one cycle. In that cycle `link_tag` = 1, `link_addr` = the `pc` before the jump plus `INSN_BYTES` (default 4), and `link_perm` = `cur_perm`.
- R10: The `link_otype` of a jump-and-link is 3 if `irq_en` was 1 before the jump and 2 if it was 0, whatever posture the target sentry applies.
- R11: With `jmp_valid` low, `pc` and `irq_en` hold and neither `fault` nor `link_we` is asserted, whatever the other inputs carry.
- R12: A faulting jump-and-link never asserts `link_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| jmp_valid | input | 1 | An indirect jump is requested this cycle |
| jmp_link | input | 1 | The jump also writes a return capability |
| tgt_tag | input | 1 | Validity tag of the target capability |
| tgt_perm | input | PERM_W | Permission bits of the target; bit EXEC_BIT grants execute |
| tgt_otype | input | 3 | Object type of the target |
| tgt_addr | input | ADDR_W | Address of the target |
| cur_perm | input | PERM_W | Permissions of the current code capability, copied into the link |
| pc | output | ADDR_W | Program counter |
| irq_en | output | 1 | Global interrupt enable |
| fault | output | 1 | One-cycle pulse for a rejected jump |
| fault_cause | output | 2 | 0 none, 1 tag, 2 seal, 3 permission |
| link_we | output | 1 | One-cycle link register write strobe |
| link_tag | output | 1 | Tag of the return capability |
| link_perm | output | PERM_W | Permissions of the return capability |
| link_otype | output | 3 | Sentry type of the return capability |
| link_addr | output | ADDR_W | Return address |

## Verification
A jump-and-link through an interrupt-changing sentry both rewrites `irq_en` and captures a posture into the return capability at the same edge. The captured value must be the old flag, not the new one. The stimulus table issues link jumps through interrupt-on and interrupt-off sentries from the opposite interrupt state. It then checks, in the cycle after the request, that `irq_en` already holds the new value while `link_otype` still encodes the previous one.

// File: rtl/sjp_pkg.sv
// Shared encodings for the sentry jump unit.
// Assumes a 3-bit object-type field and a 2-bit fault cause.
package sjp_pkg;

    typedef enum logic [2:0] {
        OT_UNSEALED   = 3'd0,
        OT_ENTRY_KEEP = 3'd1,
        OT_ENTRY_OFF  = 3'd2,
        OT_ENTRY_ON   = 3'd3
    } otype_e;

    typedef enum logic [1:0] {
        FC_NONE = 2'd0,
        FC_TAG  = 2'd1,
        FC_SEAL = 2'd2,
        FC_PERM = 2'd3
    } fault_cause_e;

    typedef enum logic [1:0] {
        POST_KEEP = 2'd0,
        POST_OFF  = 2'd1,
        POST_ON   = 2'd2
    } posture_e;

endpackage

// File: rtl/sjp_target_check.sv
// Classifies a jump target: fault cause (tag over seal over permission)
// and the interrupt posture a legal target applies. Purely combinational.
module sjp_target_check
    import sjp_pkg::*;
#(
    parameter int PERM_W   = 6,
    parameter int EXEC_BIT = 1
) (
    input  logic              tag,
    input  logic [PERM_W-1:0] perm,
    input  logic [2:0]        otype,
    output fault_cause_e      cause,
    output posture_e          posture
);
    localparam logic [PERM_W-1:0] EXEC_MASK = PERM_W'(1) << EXEC_BIT;

    logic exec_ok;
    logic entry_ok;

    // Decode execute right and whether the object type can be entered.
    always_comb begin
        exec_ok  = |(perm & EXEC_MASK);
        entry_ok = (otype[2] == 1'b0);
    end

    // Prioritised fault cause.
    always_comb begin
        if (!tag)           cause = FC_TAG;
        else if (!entry_ok) cause = FC_SEAL;
        else if (!exec_ok)  cause = FC_PERM;
        else                cause = FC_NONE;
    end

    // Posture carried by the object type; unsealed and inheriting keep state.
    always_comb begin
        unique case (otype)
            OT_ENTRY_OFF: posture = POST_OFF;
            OT_ENTRY_ON:  posture = POST_ON;
            default:      posture = POST_KEEP;
        endcase
    end
endmodule

// File: rtl/sjp_ie_next.sv
// Next value of the global interrupt enable for an accepted jump.
// Assumes the caller gates it with the accept condition.
module sjp_ie_next
    import sjp_pkg::*;
(
    input  posture_e posture,
    input  logic     ie_cur,
    output logic     ie_nxt
);
    // Apply the posture to the current flag.
    always_comb begin
        unique case (posture)
            POST_OFF: ie_nxt = 1'b0;
            POST_ON:  ie_nxt = 1'b1;
            default:  ie_nxt = ie_cur;
        endcase
    end
endmodule

// File: rtl/sjp_link_gen.sv
// Builds the return capability for jump-and-link: a tagged sentry whose
// posture matches the interrupt flag before the jump.
module sjp_link_gen
    import sjp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PERM_W     = 6,
    parameter int INSN_BYTES = 4
) (
    input  logic [ADDR_W-1:0] pc_cur,
    input  logic              ie_cur,
    input  logic [PERM_W-1:0] perm_cur,
    output logic              tag,
    output logic [PERM_W-1:0] perm,
    output logic [2:0]        otype,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    // Compose the sealed return entry.
    always_comb begin
        tag   = 1'b1;
        perm  = perm_cur;
        otype = ie_cur ? 3'(OT_ENTRY_ON) : 3'(OT_ENTRY_OFF);
        addr  = pc_cur + STEP;
    end
endmodule

// File: rtl/sentry_jump_unit.sv
// Indirect jump unit for a capability core. It validates the target,
// unseals sentries, applies their interrupt posture at the PC-update edge,
// and emits the return capability for jump-and-link.
// Assumes one jump request per cycle at most; synchronous active-low reset.
module sentry_jump_unit
    import sjp_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              PERM_W     = 6,
    parameter int              EXEC_BIT   = 1,
    parameter int              INSN_BYTES = 4,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              jmp_valid,
    input  logic              jmp_link,
    input  logic              tgt_tag,
    input  logic [PERM_W-1:0] tgt_perm,
    input  logic [2:0]        tgt_otype,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [PERM_W-1:0] cur_perm,
    output logic [ADDR_W-1:0] pc,
    output logic              irq_en,
    output logic              fault,
    output logic [1:0]        fault_cause,
    output logic              link_we,
    output logic              link_tag,
    output logic [PERM_W-1:0] link_perm,
    output logic [2:0]        link_otype,
    output logic [ADDR_W-1:0] link_addr
);
    fault_cause_e      cause;
    posture_e          posture;
    logic              ie_nxt;
    logic              accept;
    logic              reject;
    logic              l_tag;
    logic [PERM_W-1:0] l_perm;
    logic [2:0]        l_otype;
    logic [ADDR_W-1:0] l_addr;

    sjp_target_check #(.PERM_W(PERM_W), .EXEC_BIT(EXEC_BIT)) u_check (
        .tag     (tgt_tag),
        .perm    (tgt_perm),
        .otype   (tgt_otype),
        .cause   (cause),
        .posture (posture)
    );

    sjp_ie_next u_ie (
        .posture (posture),
        .ie_cur  (irq_en),
        .ie_nxt  (ie_nxt)
    );

    sjp_link_gen #(.ADDR_W(ADDR_W), .PERM_W(PERM_W), .INSN_BYTES(INSN_BYTES)) u_link (
        .pc_cur   (pc),
        .ie_cur   (irq_en),
        .perm_cur (cur_perm),
        .tag      (l_tag),
        .perm     (l_perm),
        .otype    (l_otype),
        .addr     (l_addr)
    );

    // Split the request into accepted and rejected jumps.
    always_comb begin
        accept = jmp_valid && (cause == FC_NONE);
        reject = jmp_valid && (cause != FC_NONE);
    end

    // PC and interrupt flag move together so the new posture covers the target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc     <= RESET_PC;
            irq_en <= 1'b0;
        end else if (accept) begin
            pc     <= tgt_addr;
            irq_en <= ie_nxt;
        end
    end

    // One-cycle fault pulse with its cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault       <= 1'b0;
            fault_cause <= 2'd0;
        end else begin
            fault       <= reject;
            fault_cause <= reject ? 2'(cause) : 2'd0;
        end
    end

    // Link register write strobe and captured return capability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_we    <= 1'b0;
            link_tag   <= 1'b0;
            link_perm  <= '0;
            link_otype <= 3'd0;
            link_addr  <= '0;
        end else begin
            link_we <= accept && jmp_link;
            if (accept && jmp_link) begin
                link_tag   <= l_tag;
                link_perm  <= l_perm;
                link_otype <= l_otype;
                link_addr  <= l_addr;
            end
        end
    end

    // R2
    fault_keeps_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($stable(pc) && $stable(irq_en)));

    // R12
    fault_no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault, link_we}));

    // R10
    link_posture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_otype == ($past(irq_en) ? 3'd3 : 3'd2)));

    // R9
    link_tagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_tag && (link_addr == $past(pc) + ADDR_W'(INSN_BYTES))));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && !$past(jmp_valid)) |-> (!fault && !link_we && $stable(pc)));

    // R4
    cause_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_cause != 2'd0) |-> fault);
endmodule

// File: tb/sentry_jump_unit_test.sv
module sentry_jump_unit_test;
    localparam int AW = 32;
    localparam int PW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          jmp_valid, jmp_link, tgt_tag;
    logic [PW-1:0] tgt_perm, cur_perm;
    logic [2:0]    tgt_otype;
    logic [AW-1:0] tgt_addr;
    logic [AW-1:0] pc;
    logic          irq_en, fault, link_we, link_tag;
    logic [1:0]    fault_cause;
    logic [PW-1:0] link_perm;
    logic [2:0]    link_otype;
    logic [AW-1:0] link_addr;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    sentry_jump_unit uut (
        .clk(clk), .rst_n(rst_n), .jmp_valid(jmp_valid), .jmp_link(jmp_link),
        .tgt_tag(tgt_tag), .tgt_perm(tgt_perm), .tgt_otype(tgt_otype),
        .tgt_addr(tgt_addr), .cur_perm(cur_perm), .pc(pc), .irq_en(irq_en),
        .fault(fault), .fault_cause(fault_cause), .link_we(link_we),
        .link_tag(link_tag), .link_perm(link_perm), .link_otype(link_otype),
        .link_addr(link_addr)
    );

    // Vector: {link, tag, perm[6], otype[3], addr[32], cause[2], iemode[2]}
    // iemode: 0 keep, 1 clear, 2 set
    localparam int NV = 12;
    localparam logic [46:0] VEC [NV] = '{
        {1'b0, 1'b1, 6'h02, 3'd0, 32'h100, 2'd0, 2'd0}, // R5 plain jump
        {1'b1, 1'b1, 6'h3F, 3'd3, 32'h200, 2'd0, 2'd2}, // R8 R10 enable, link from off
        {1'b1, 1'b1, 6'h02, 3'd1, 32'h300, 2'd0, 2'd0}, // R6 inherit
        {1'b1, 1'b1, 6'h3E, 3'd2, 32'h400, 2'd0, 2'd1}, // R7 R10 disable, link from on
        {1'b1, 1'b0, 6'h02, 3'd3, 32'h500, 2'd1, 2'd0}, // R2 R12 untagged
        {1'b0, 1'b1, 6'h02, 3'd5, 32'h510, 2'd2, 2'd0}, // R3 sealed other
        {1'b1, 1'b1, 6'h3D, 3'd0, 32'h520, 2'd3, 2'd0}, // R4 no execute
        {1'b0, 1'b0, 6'h01, 3'd6, 32'h530, 2'd1, 2'd0}, // R4 priority tag
        {1'b0, 1'b1, 6'h01, 3'd7, 32'h540, 2'd2, 2'd0}, // R4 priority seal
        {1'b0, 1'b1, 6'h01, 3'd2, 32'h550, 2'd3, 2'd0}, // R4 sentry no execute
        {1'b0, 1'b1, 6'h02, 3'd3, 32'h600, 2'd0, 2'd2}, // R8 enable, no link
        {1'b1, 1'b1, 6'h06, 3'd0, 32'h700, 2'd0, 2'd0}  // R9 R10 link while on
    };

    logic [AW-1:0] m_pc;
    logic          m_ie;

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        jmp_valid = 1'b0; jmp_link = 1'b0; tgt_tag = 1'b0; tgt_perm = '0;
        tgt_otype = 3'd0; tgt_addr = '0;
    endtask

    initial begin
        cur_perm = 6'h2A;
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pc", pc, 32'h0);
        chk("R1 irq_en", {31'd0, irq_en}, 32'd0);
        chk("R1 fault", {31'd0, fault}, 32'd0);
        chk("R1 link_we", {31'd0, link_we}, 32'd0);
        rst_n = 1'b1;
        m_pc = '0; m_ie = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [46:0] v;
            logic [1:0]  ec, im;
            logic        lk;
            v = VEC[i];
            @(negedge clk);
            jmp_valid = 1'b1; jmp_link = v[46]; tgt_tag = v[45]; tgt_perm = v[44:39];
            tgt_otype = v[38:36]; tgt_addr = v[35:4];
            ec = v[3:2]; im = v[1:0]; lk = v[46];
            @(negedge clk);
            chk("R2 R3 R4 fault", {31'd0, fault}, {31'd0, ec != 2'd0});
            chk("R2 R3 R4 fault_cause", {30'd0, fault_cause}, {30'd0, ec});
            chk("R9 R12 link_we", {31'd0, link_we}, {31'd0, lk && ec == 2'd0});
            if (lk && ec == 2'd0) begin
                chk("R10 link_otype", {29'd0, link_otype}, {29'd0, m_ie ? 3'd3 : 3'd2});
                chk("R9 link_addr", link_addr, m_pc + 32'd4);
                chk("R9 link_tag", {31'd0, link_tag}, 32'd1);
                chk("R9 link_perm", {26'd0, link_perm}, {26'd0, cur_perm});
            end
            if (ec == 2'd0) begin
                m_pc = v[35:4];
                if (im == 2'd1) m_ie = 1'b0;
                else if (im == 2'd2) m_ie = 1'b1;
            end
            chk("R5 R6 pc", pc, m_pc);
            chk("R7 R8 irq_en", {31'd0, irq_en}, {31'd0, m_ie});
            idle_inputs();
        end

        // R11 idle with busy-looking inputs and valid low
        @(negedge clk);
        jmp_link = 1'b1; tgt_tag = 1'b1; tgt_perm = 6'h3F; tgt_otype = 3'd2; tgt_addr = 32'hDEAD0;
        @(negedge clk);
        chk("R11 pc", pc, m_pc);
        chk("R11 irq_en", {31'd0, irq_en}, {31'd0, m_ie});
        chk("R11 fault", {31'd0, fault}, 32'd0);
        chk("R11 link_we", {31'd0, link_we}, 32'd0);
        idle_inputs();

        // R1 reset mid-run with a pending legal jump
        @(negedge clk);
        rst_n = 1'b0;
        jmp_valid = 1'b1; tgt_tag = 1'b1; tgt_perm = 6'h02; tgt_otype = 3'd3; tgt_addr = 32'h900;
        @(negedge clk);
        chk("R1 pc after reset", pc, 32'h0);
        chk("R1 irq_en after reset", {31'd0, irq_en}, 32'd0);
        idle_inputs();
        rst_n = 1'b1;
        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule